// File: doc/BRIEF.md
# Character Display Output Port

This block is a character output port placed on a 16-bit memory-mapped bus. A processor polls a status word to learn whether the display can take another character. When the display is free, the processor writes the character into a data word. The port keeps a single ready flag. It forwards each accepted character to the display electronics as an 8-bit value with a one-cycle strobe, and then waits for a done pulse from the display before it reports ready again.

A data write that arrives while the display is busy is dropped. It is not queued, and it produces no strobe. Software that polls the status word before each write therefore never loses a character, and each accepted character reaches the display exactly once. Bus accesses to any address other than the two decoded words are ignored.

Top module: `char_out_port`

## Requirements
- R1: After a synchronous active-low reset, the ready flag is one and `disp_stb` is low.
- R2: A read of the status word at address 0xF3FC returns the ready flag in bit 15 and zero in bits [14:0].
- R3: A write to the data word at address 0xF3FF while ready is one raises `disp_stb` for exactly one cycle, starting the cycle after the write edge, with `disp_char` equal to write data bits [7:0]; bits [15:8] of the write are discarded.
- R4: An accepted data write clears the ready flag, so the status word reads 0x0000 from the cycle after the write.
- R5: A data write made while ready is zero is ignored: no strobe is produced and the stored character is unchanged.
- R6: A one-cycle `disp_done` pulse while ready is zero sets the ready flag, which is visible in the status word on the next cycle.
- R7: A read of the data word returns the last accepted character in bits [7:0] and zero in bits [15:8]; after reset it reads 0x0000.
- R8: Reads of any other address return 0x0000, and writes to any other address change neither the ready flag nor the stored character, and produce no strobe.
- R9: Writes to the status word have no effect on the ready flag, the stored character or the strobe.
- R10: `bus_rdata` is 0x0000 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Bus word address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| disp_char | output | 8 | Character presented to the display electronics |
| disp_stb | output | 1 | One-cycle strobe marking a new character |
| disp_done | input | 1 | Pulse from the display electronics when it can take another character |

## Verification
The checker watches several properties on every cycle. It confirms that a strobe always leaves the flag cleared and that a strobe never lasts longer than one cycle. It confirms that a write while busy is never followed by a strobe, and that a done pulse always restores ready. It also confirms that reads of the status word keep bits [14:0] at zero, and that reads of undecoded addresses or idle reads return zero. Other behaviour is shown only by the bench scenarios: the exact value carried by `disp_char`, the stored character surviving dropped and misaddressed writes, the full write-busy-done-ready round trip against a display model with a fixed latency, and one strobe per accepted character across a sequence.

// File: rtl/char_out_pkg.sv
// Package: shared types for the character output port.
// Assumes nothing beyond standard SystemVerilog.
package char_out_pkg;

    // Which register the current bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/char_out_decode.sv
// Module: char_out_decode
// Maps a bus address to a register selection. It is purely combinational.
// Assumes the two addresses are distinct.
module char_out_decode
    import char_out_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF3FC,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hF3FF
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Compare the address against the two decoded words.
    always_comb begin
        if (addr == STAT_ADDR)      sel = SEL_STAT;
        else if (addr == DATA_ADDR) sel = SEL_DATA;
        else                        sel = SEL_NONE;
    end

endmodule

// File: rtl/char_out_ctrl.sv
// Module: char_out_ctrl
// Holds the ready flag and the last accepted character, and issues the
// one-cycle strobe. Assumes done only matters while ready is low.
module char_out_ctrl #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              done,
    output logic              ready,
    output logic [CHAR_W-1:0] char_q,
    output logic              stb
);

    logic accept;

    // A data write is taken only while the display is free.
    always_comb accept = data_wr && ready;

    // Ready flag: cleared by an accepted write, set again by done.
    always_ff @(posedge clk) begin
        if (!rst_n)               ready <= 1'b1;
        else if (accept)          ready <= 1'b0;
        else if (done && !ready)  ready <= 1'b1;
    end

    // Character register: captures the accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n)      char_q <= '0;
        else if (accept) char_q <= wr_char;
    end

    // Strobe: high for the one cycle after an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) stb <= 1'b0;
        else        stb <= accept;
    end

endmodule

// File: rtl/char_out_rdmux.sv
// Module: char_out_rdmux
// Builds the read data word from the selection. It is combinational, and
// all unused bits read as zero. Assumes READY_BIT >= CHAR_W.
module char_out_rdmux
    import char_out_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CHAR_W    = 8,
    parameter int READY_BIT = 15
) (
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic              ready,
    input  logic [CHAR_W-1:0] char_q,
    output logic [DATA_W-1:0] rdata
);

    // Drive only the addressed register during a read.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_STAT: rdata[READY_BIT]   = ready;
                SEL_DATA: rdata[CHAR_W-1:0]  = char_q;
                default:  rdata              = '0;
            endcase
        end
    end

endmodule

// File: rtl/char_out_port.sv
// Module: char_out_port
// Memory-mapped character output port with status and data words.
// Assumes the bus asserts at most one of read or write per cycle.
module char_out_port
    import char_out_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                CHAR_W    = 8,
    parameter int                READY_BIT = 15,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF3FC,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hF3FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CHAR_W-1:0] disp_char,
    output logic              disp_stb,
    input  logic              disp_done
);

    reg_sel_e          sel;
    logic              data_wr;
    logic              ready_q;
    logic [CHAR_W-1:0] char_q;

    char_out_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .addr(bus_addr), .sel(sel)
    );

    // Qualify the write strobe with the data-word selection.
    always_comb data_wr = bus_wr && (sel == SEL_DATA);

    char_out_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr),
        .wr_char(bus_wdata[CHAR_W-1:0]), .done(disp_done),
        .ready(ready_q), .char_q(char_q), .stb(disp_stb)
    );

    char_out_rdmux #(
        .DATA_W(DATA_W), .CHAR_W(CHAR_W), .READY_BIT(READY_BIT)
    ) u_rd (
        .rd(bus_rd), .sel(sel), .ready(ready_q), .char_q(char_q),
        .rdata(bus_rdata)
    );

    // The display sees the stored character; it is valid while disp_stb is high.
    always_comb disp_char = char_q;

endmodule

// File: rtl/char_out_port_chk.sv
// Module: char_out_port_chk
// Cycle-by-cycle checks on the port, attached through bind.
module char_out_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                READY_BIT = 15,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF3FC,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hF3FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              disp_stb,
    input logic              disp_done,
    input logic              ready_q
);

    // R4: a strobe always comes with the flag already cleared
    a_r4_stb_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stb |-> !ready_q);

    // R3: the strobe lasts one cycle
    a_r3_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stb |=> !disp_stb);

    // R5: a write while busy never yields a strobe
    a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_ADDR && !ready_q) |=> !disp_stb);

    // R6: done restores ready
    a_r6_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_done && !ready_q) |=> ready_q);

    // R2: low status bits read zero
    a_r2_stat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STAT_ADDR) |-> (bus_rdata[READY_BIT-1:0] == '0));

    // R8: undecoded reads return zero
    a_r8_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != STAT_ADDR && bus_addr != DATA_ADDR) |-> (bus_rdata == '0));

    // R10: no read, no data
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

bind char_out_port char_out_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READY_BIT(READY_BIT),
    .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .disp_stb(disp_stb),
    .disp_done(disp_done), .ready_q(ready_q)
);

// File: tb/char_out_port_test.sv
// Directed bench for char_out_port; the display is modelled with a fixed latency.
module char_out_port_test;

    localparam logic [15:0] STAT = 16'hF3FC;
    localparam logic [15:0] DATA = 16'hF3FF;
    localparam int          LAT  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  disp_char;
    logic        disp_stb;
    logic        disp_done;

    logic        model_done = 1'b0;
    logic        man_done = 1'b0;
    logic        auto_en = 1'b1;
    int          cnt = 0;
    int          stb_count = 0;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    assign disp_done = model_done | man_done;

    char_out_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .disp_char(disp_char), .disp_stb(disp_stb), .disp_done(disp_done)
    );

    // Display model: done pulse LAT cycles after each strobe.
    always @(posedge clk) begin
        model_done <= 1'b0;
        if (disp_stb && auto_en) cnt <= LAT;
        else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) model_done <= 1'b1;
        end
        if (rst_n && disp_stb) stb_count <= stb_count + 1;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic wait_ready();
        logic [15:0] s;
        for (int i = 0; i < 50; i++) begin
            bus_read(STAT, s);
            if (s[15]) return;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 strobe low", {15'b0, disp_stb}, 16'h0000);
        bus_read(STAT, v); check("R1 R2 status after reset", v, 16'h8000);
        bus_read(DATA, v); check("R7 data after reset", v, 16'h0000);
    endtask

    task automatic t_accept();
        logic [15:0] v;
        int s0 = stb_count;
        bus_write(DATA, 16'hAB41);
        check("R3 strobe", {15'b0, disp_stb}, 16'h0001);
        check("R3 char low byte only", {8'b0, disp_char}, 16'h0041);
        bus_read(STAT, v); check("R4 ready cleared", v, 16'h0000);
        check("R3 strobe single", {15'b0, disp_stb}, 16'h0000);
        wait_ready();
        bus_read(STAT, v); check("R6 ready back", v, 16'h8000);
        bus_read(DATA, v); check("R7 data readback", v, 16'h0041);
        check("R3 one strobe", 16'(stb_count - s0), 16'h0001);
    endtask

    task automatic t_busy_drop();
        logic [15:0] v;
        int s0 = stb_count;
        auto_en = 1'b0;
        bus_write(DATA, 16'h0058);
        @(negedge clk);
        bus_write(DATA, 16'h0059);
        check("R5 no strobe while busy", {15'b0, disp_stb}, 16'h0000);
        bus_read(DATA, v); check("R5 char kept", v, 16'h0058);
        bus_read(STAT, v); check("R5 still busy", v, 16'h0000);
        man_done = 1'b1; @(negedge clk); man_done = 1'b0;
        bus_read(STAT, v); check("R6 done sets ready", v, 16'h8000);
        check("R5 single strobe", 16'(stb_count - s0), 16'h0001);
        auto_en = 1'b1;
    endtask

    task automatic t_other_addr();
        logic [15:0] v;
        int s0 = stb_count;
        bus_write(16'hF3FD, 16'h0033);
        check("R8 no strobe other addr", {15'b0, disp_stb}, 16'h0000);
        bus_read(STAT, v); check("R8 ready kept", v, 16'h8000);
        bus_read(DATA, v); check("R8 char kept", v, 16'h0058);
        bus_read(16'hF3FE, v); check("R8 read F3FE", v, 16'h0000);
        bus_read(16'hF400, v); check("R8 read F400", v, 16'h0000);
        check("R8 strobe count", 16'(stb_count - s0), 16'h0000);
    endtask

    task automatic t_status_write();
        logic [15:0] v;
        bus_write(STAT, 16'h0000);
        check("R9 no strobe", {15'b0, disp_stb}, 16'h0000);
        bus_read(STAT, v); check("R9 ready kept", v, 16'h8000);
        bus_read(DATA, v); check("R9 char kept", v, 16'h0058);
    endtask

    task automatic t_idle_read();
        bus_addr = STAT; bus_rd = 1'b0;
        #1 check("R10 idle read zero", bus_rdata, 16'h0000);
        @(negedge clk);
        bus_addr = 16'h0000;
    endtask

    task automatic t_sequence();
        logic [15:0] v;
        int s0 = stb_count;
        for (int i = 0; i < 4; i++) begin
            bus_write(DATA, 16'(16'h0060 + i));
            check("R3 seq char", {8'b0, disp_char}, 16'(16'h0060 + i));
            wait_ready();
        end
        bus_read(DATA, v); check("R7 last char", v, 16'h0063);
        check("R3 seq strobes", 16'(stb_count - s0), 16'h0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accept();
        t_busy_drop();
        t_other_addr();
        t_status_write();
        t_idle_read();
        t_sequence();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule